// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block is the processor-side engine that runs read and write transfers over a bus where address and data share the same wires. Each transfer is built from four bus states, T1 to T4. Each state lasts two clocks, which gives a first half and a second half. A READY input can stretch the transfer with extra wait states. The sequencer puts the address out in T1 and pulses a latch strobe so that an external latch can hold it. It then either floats the bus for a read or drives write data, and it steers the byte lanes of a 16-bit word.

A client presents a request with an address, a read/write flag, a memory-or-I/O flag, a byte/word size and write data. It is taken when `req_valid` is high on a clock where `req_ready` is high. Read results come back on `rd_data` with a one-clock `rd_valid` pulse. The shared bus is `bus_out`/`bus_oe` outward and `bus_in` inward. The data lanes are the low 16 bits of the bus.

Top module: `mux_bus_seq`

## Requirements
- R1: A request is taken only on a clock where the sequencer is idle or in the second clock of T4; `req_ready` shows this. `busy` is high from the first clock of T1 until T4 ends, and a request offered at any other time has no effect.
- R2: `ale` is high for exactly one clock, the first clock of T1. Throughout T1, `bus_oe` is high and `bus_out` carries the full request address.
- R3: `mem_io` (1 = memory), `dt_r` (0 = read, 1 = write) and `bhe_n` hold constant from T1 through T4. When idle they rest at 0, 0 and 1.
- R4: `bhe_n` is low for a word transfer and for a byte at an odd address, and high for a byte at an even address. A byte write places the low byte of the write data on both bit lanes [15:8] and [7:0].
- R5: In a read, `bus_oe` is low from T2 onward. `rd_n` goes low on the second clock of T2 and stays low through the last clock of T3 or of the last wait state.
- R6: In a write, `wr_n` goes low on the first clock of T2 and stays low through the last clock of T3 or of the last wait state. The lane data is driven with `bus_oe` high from T2 through the first clock of T4.
- R7: `den` is high from the first clock of T2 until the end of T4, and low at all other times.
- R8: READY is examined only on the last clock of T3 and of each wait state. If it is low there, a two-clock wait state follows, with the strobes still active. READY on any other clock has no effect.
- R9: At the READY sampling point that ends a read, `bus_in` is captured. `rd_valid` is high for the first clock of T4. `rd_data` holds the word, or the addressed byte zero-extended (bits [15:8] for an odd address, [7:0] for an even one).
- R10: A request taken in the second clock of T4 starts T1 on the very next clock, with no idle clock in between.
- R11: While reset is high and on the first clock after it, the sequencer is idle: `busy`, `ale`, `den`, `bus_oe` and `rd_valid` are low, `rd_n` and `wr_n` are high, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this clock |
| req_addr | input | AW (20) | Transfer address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_byte | input | 1 | 1 = byte transfer, 0 = word |
| req_wdata | input | DW (16) | Write data |
| ready | input | 1 | Device ready, sampled at the end of T3 and of wait states |
| bus_in | input | AW (20) | Shared bus as seen at the pins |
| bus_out | output | AW (20) | Value driven onto the shared bus |
| bus_oe | output | 1 | Drive enable for the shared bus |
| ale | output | 1 | Address latch strobe |
| mem_io | output | 1 | Memory/I/O qualifier |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den | output | 1 | Transceiver enable, active high |
| dt_r | output | 1 | Transceiver direction, high for write |
| bhe_n | output | 1 | High byte enable, active low |
| busy | output | 1 | Transfer in progress |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | DW (16) | Read result |

## Verification
Two events can fall on the same clock: the end of one transfer in the second clock of T4, and the acceptance of the next request. The bench provokes this by holding a new request at the end of a read. It then requires `req_ready` high there and `ale` with the new address on the very next clock. A second collision is READY landing on a clock that is not a sampling point. The bench raises READY in the first half of T3, drops it in the second half, and expects a wait state with `rd_n` still low and no `rd_valid`.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_T3   = 3'd3,
        ST_TW   = 3'd4,
        ST_T4   = 3'd5
    } bus_state_e;

    typedef struct packed {
        logic write;
        logic mem;
        logic byte_op;
    } cyc_kind_t;

    localparam cyc_kind_t KIND_NONE = '{write: 1'b0, mem: 1'b0, byte_op: 1'b0};

    // high byte lane is idle only for a byte at an even address
    function automatic logic hi_lane_off(input logic byte_op, input logic a0);
        return byte_op & ~a0;
    endfunction

    function automatic logic in_data_phase(input bus_state_e s);
        return (s == ST_T2) || (s == ST_T3) || (s == ST_TW) || (s == ST_T4);
    endfunction

    function automatic logic in_strobe_window(input bus_state_e s);
        return (s == ST_T2) || (s == ST_T3) || (s == ST_TW);
    endfunction

endpackage

// File: rtl/mbs_seq.sv
module mbs_seq
    import mbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       ready,
    output bus_state_e state_o,
    output logic       ph_o,
    output logic       can_take_o,
    output logic       sample_o
);
    bus_state_e state_q;
    logic       ph_q;

    assign sample_o   = ph_q && ((state_q == ST_T3) || (state_q == ST_TW));
    assign can_take_o = (state_q == ST_IDLE) || ((state_q == ST_T4) && ph_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ph_q    <= 1'b0;
        end else if (state_q == ST_IDLE) begin
            ph_q <= 1'b0;
            if (start) state_q <= ST_T1;
        end else if (!ph_q) begin
            ph_q <= 1'b1;
        end else begin
            ph_q <= 1'b0;
            case (state_q)
                ST_T1:        state_q <= ST_T2;
                ST_T2:        state_q <= ST_T3;
                ST_T3, ST_TW: state_q <= ready ? ST_T4 : ST_TW;
                ST_T4:        state_q <= start ? ST_T1 : ST_IDLE;
                default:      state_q <= ST_IDLE;
            endcase
        end
    end

    assign state_o = state_q;
    assign ph_o    = ph_q;
endmodule

// File: rtl/mbs_lane.sv
module mbs_lane #(
    parameter int DW = 16
) (
    input  logic          byte_op,
    input  logic          a0,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] bus_rd,
    output logic          hbe_n,
    output logic [DW-1:0] lane_wdata,
    output logic [DW-1:0] rd_ext
);
    import mbs_pkg::*;
    localparam int HB = DW / 2;

    logic [HB-1:0] sel_byte;

    assign hbe_n = hi_lane_off(byte_op, a0);

    generate
        for (genvar g = 0; g < 2; g++) begin : g_lane
            assign lane_wdata[g*HB +: HB] = byte_op ? wdata[HB-1:0] : wdata[g*HB +: HB];
        end
    endgenerate

    assign sel_byte = a0 ? bus_rd[DW-1:HB] : bus_rd[HB-1:0];
    assign rd_ext   = byte_op ? {{(DW-HB){1'b0}}, sel_byte} : bus_rd;
endmodule

// File: rtl/mbs_drive.sv
module mbs_drive
    import mbs_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  bus_state_e    state,
    input  logic          ph,
    input  cyc_kind_t     kind,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] lane_wd,
    input  logic          hbe_n_cur,
    output logic [AW-1:0] bus_out,
    output logic          bus_oe,
    output logic          ale,
    output logic          mem_io,
    output logic          rd_n,
    output logic          wr_n,
    output logic          den,
    output logic          dt_r,
    output logic          bhe_n,
    output logic          busy
);
    localparam int PAD = AW - DW;

    logic in_cyc, addr_ph, wdata_ph;

    assign in_cyc   = (state != ST_IDLE);
    assign addr_ph  = (state == ST_T1);
    assign wdata_ph = kind.write && (in_strobe_window(state) || ((state == ST_T4) && !ph));

    assign busy   = in_cyc;
    assign ale    = addr_ph && !ph;
    assign bus_oe = addr_ph || wdata_ph;
    assign bus_out = addr_ph ? addr : (wdata_ph ? {{PAD{1'b0}}, lane_wd} : '0);
    assign mem_io = in_cyc && kind.mem;
    assign dt_r   = in_cyc && kind.write;
    assign bhe_n  = in_cyc ? hbe_n_cur : 1'b1;
    assign den    = in_data_phase(state);
    assign wr_n   = !(kind.write && in_strobe_window(state));
    assign rd_n   = !(!kind.write && in_strobe_window(state) && !((state == ST_T2) && !ph));
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
    import mbs_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic          req_write,
    input  logic          req_mem,
    input  logic          req_byte,
    input  logic [DW-1:0] req_wdata,
    input  logic          ready,
    input  logic [AW-1:0] bus_in,
    output logic [AW-1:0] bus_out,
    output logic          bus_oe,
    output logic          ale,
    output logic          mem_io,
    output logic          rd_n,
    output logic          wr_n,
    output logic          den,
    output logic          dt_r,
    output logic          bhe_n,
    output logic          busy,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    bus_state_e    state;
    logic          ph, can_take, sample, start;
    cyc_kind_t     kind_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q, lane_wd, rd_ext;
    logic          hbe_n_cur;

    assign start     = req_valid && can_take;
    assign req_ready = can_take;

    mbs_seq u_seq (
        .clk(clk), .rst(rst), .start(start), .ready(ready),
        .state_o(state), .ph_o(ph), .can_take_o(can_take), .sample_o(sample)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q  <= KIND_NONE;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (start) begin
            kind_q  <= '{write: req_write, mem: req_mem, byte_op: req_byte};
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    mbs_lane #(.DW(DW)) u_lane (
        .byte_op(kind_q.byte_op), .a0(addr_q[0]), .wdata(wdata_q),
        .bus_rd(bus_in[DW-1:0]), .hbe_n(hbe_n_cur),
        .lane_wdata(lane_wd), .rd_ext(rd_ext)
    );

    mbs_drive #(.AW(AW), .DW(DW)) u_drive (
        .state(state), .ph(ph), .kind(kind_q), .addr(addr_q),
        .lane_wd(lane_wd), .hbe_n_cur(hbe_n_cur),
        .bus_out(bus_out), .bus_oe(bus_oe), .ale(ale), .mem_io(mem_io),
        .rd_n(rd_n), .wr_n(wr_n), .den(den), .dt_r(dt_r), .bhe_n(bhe_n),
        .busy(busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= sample && ready && !kind_q.write;
            if (sample && ready && !kind_q.write) rd_data <= rd_ext;
        end
    end
endmodule

// File: rtl/mux_bus_seq_chk.sv
module mux_bus_seq_chk (
    input logic clk,
    input logic rst,
    input logic req_ready,
    input logic ready,
    input logic bus_oe,
    input logic ale,
    input logic mem_io,
    input logic rd_n,
    input logic wr_n,
    input logic den,
    input logic dt_r,
    input logic bhe_n,
    input logic busy,
    input logic rd_valid
);
    assert_accept_window_R1: assert property (@(posedge clk) disable iff (rst)
        (req_ready && busy) |-> (rd_n && wr_n && den && !ale));

    assert_ale_single_R2: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale);

    assert_ale_addr_R2: assert property (@(posedge clk) disable iff (rst)
        ale |-> (bus_oe && busy));

    assert_qual_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && !ale) |-> ($stable(mem_io) && $stable(dt_r) && $stable(bhe_n)));

    assert_read_float_R5: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> (!bus_oe && !dt_r));

    assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (rst)
        busy |-> (rd_n || wr_n));

    assert_den_in_cycle_R7: assert property (@(posedge clk) disable iff (rst)
        den |-> busy);

    assert_ready_gate_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_valid) |-> $past(ready));

    assert_rdv_read_R9: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (!dt_r && rd_n && den));
endmodule

bind mux_bus_seq mux_bus_seq_chk u_chk (
    .clk(clk), .rst(rst), .req_ready(req_ready), .ready(ready),
    .bus_oe(bus_oe), .ale(ale), .mem_io(mem_io), .rd_n(rd_n), .wr_n(wr_n),
    .den(den), .dt_r(dt_r), .bhe_n(bhe_n), .busy(busy), .rd_valid(rd_valid)
);

// File: tb/mux_bus_seq_tb.sv
`timescale 1ns/1ps
module mux_bus_seq_tb;
    localparam int AW = 20;
    localparam int DW = 16;

    typedef struct packed {
        logic        wr;
        logic        mem;
        logic        byt;
        logic [19:0] addr;
        logic [15:0] wd;
        logic [3:0]  waits;
        logic [15:0] busv;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{wr:1'b0, mem:1'b1, byt:1'b0, addr:20'h12340, wd:16'h0000, waits:4'd0, busv:16'hBEEF},
        '{wr:1'b1, mem:1'b0, byt:1'b0, addr:20'h00080, wd:16'hA55A, waits:4'd0, busv:16'h0000},
        '{wr:1'b0, mem:1'b1, byt:1'b1, addr:20'h00101, wd:16'h0000, waits:4'd2, busv:16'h7788},
        '{wr:1'b0, mem:1'b1, byt:1'b1, addr:20'h00200, wd:16'h0000, waits:4'd1, busv:16'h7788},
        '{wr:1'b1, mem:1'b0, byt:1'b1, addr:20'h00033, wd:16'h00C3, waits:4'd3, busv:16'h0000},
        '{wr:1'b1, mem:1'b1, byt:1'b1, addr:20'hFFFFE, wd:16'h1234, waits:4'd0, busv:16'h0000}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0, req_mem = 1'b0, req_byte = 1'b0;
    logic [AW-1:0] req_addr = '0, bus_in = '0;
    logic [DW-1:0] req_wdata = '0;
    logic ready = 1'b1;
    logic req_ready, bus_oe, ale, mem_io, rd_n, wr_n, den, dt_r, bhe_n, busy, rd_valid;
    logic [AW-1:0] bus_out;
    logic [DW-1:0] rd_data;

    int total = 0, bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    mux_bus_seq #(.AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_mem(req_mem),
        .req_byte(req_byte), .req_wdata(req_wdata), .ready(ready),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .ale(ale),
        .mem_io(mem_io), .rd_n(rd_n), .wr_n(wr_n), .den(den), .dt_r(dt_r),
        .bhe_n(bhe_n), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic logic [15:0] exp_lane(input vec_t v);
        return v.byt ? {v.wd[7:0], v.wd[7:0]} : v.wd;
    endfunction

    function automatic logic [15:0] exp_rd(input vec_t v);
        if (!v.byt) return v.busv;
        return v.addr[0] ? {8'h00, v.busv[15:8]} : {8'h00, v.busv[7:0]};
    endfunction

    task automatic offer(input vec_t v);
        req_valid = 1'b1; req_addr = v.addr; req_write = v.wr;
        req_mem = v.mem; req_byte = v.byt; req_wdata = v.wd;
    endtask

    task automatic run_vec(input vec_t v);
        chk("R1", "req_ready idle", {31'd0, req_ready}, 32'd1);
        offer(v);
        bus_in = {4'h0, v.busv};
        step();                               // T1 first clock
        req_valid = 1'b0;
        chk("R2", "ale T1", {31'd0, ale}, 32'd1);
        chk("R2", "addr T1", {12'd0, bus_out}, {12'd0, v.addr});
        chk("R1", "busy T1", {31'd0, busy}, 32'd1);
        chk("R3", "mem_io", {31'd0, mem_io}, {31'd0, v.mem});
        chk("R3", "dt_r", {31'd0, dt_r}, {31'd0, v.wr});
        chk("R4", "bhe_n", {31'd0, bhe_n}, {31'd0, v.byt & ~v.addr[0]});
        step();                               // T1 second clock
        chk("R2", "ale low", {31'd0, ale}, 32'd0);
        chk("R2", "oe T1b", {31'd0, bus_oe}, 32'd1);
        step();                               // T2 first clock
        chk("R7", "den T2", {31'd0, den}, 32'd1);
        chk("R6", "wr_n T2a", {31'd0, wr_n}, {31'd0, ~v.wr});
        chk("R5", "rd_n T2a", {31'd0, rd_n}, 32'd1);
        chk("R5", "oe T2", {31'd0, bus_oe}, {31'd0, v.wr});
        chk("R1", "req_ready T2", {31'd0, req_ready}, 32'd0);
        if (v.wr) chk("R4", "lane data", {16'd0, bus_out[15:0]}, {16'd0, exp_lane(v)});
        step();                               // T2 second clock
        chk("R5", "rd_n T2b", {31'd0, rd_n}, {31'd0, v.wr});
        step();                               // T3 first clock
        ready = (v.waits == 0);
        step();                               // T3 second clock
        for (int w = 0; w < int'(v.waits); w++) begin
            step();                           // wait state first clock
            chk("R8", "rd_n wait", {31'd0, rd_n}, {31'd0, v.wr});
            chk("R8", "wr_n wait", {31'd0, wr_n}, {31'd0, ~v.wr});
            chk("R8", "no rd_valid", {31'd0, rd_valid}, 32'd0);
            ready = (w == int'(v.waits) - 1);
            step();                           // wait state second clock
        end
        step();                               // T4 first clock
        ready = 1'b1;
        chk("R5", "rd_n T4", {31'd0, rd_n}, 32'd1);
        chk("R6", "wr_n T4", {31'd0, wr_n}, 32'd1);
        chk("R6", "oe T4a", {31'd0, bus_oe}, {31'd0, v.wr});
        chk("R9", "rd_valid", {31'd0, rd_valid}, {31'd0, ~v.wr});
        if (!v.wr) chk("R9", "rd_data", {16'd0, rd_data}, {16'd0, exp_rd(v)});
        step();                               // T4 second clock
        chk("R6", "oe T4b", {31'd0, bus_oe}, 32'd0);
        chk("R7", "den T4b", {31'd0, den}, 32'd1);
        chk("R1", "req_ready T4b", {31'd0, req_ready}, 32'd1);
        chk("R3", "dt_r hold", {31'd0, dt_r}, {31'd0, v.wr});
        step();                               // idle
        chk("R1", "busy end", {31'd0, busy}, 32'd0);
        chk("R7", "den idle", {31'd0, den}, 32'd0);
        chk("R3", "bhe_n idle", {31'd0, bhe_n}, 32'd1);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        vec_t a, b;
        rst = 1'b1;
        repeat (3) step();
        // R11 reset state
        chk("R11", "busy", {31'd0, busy}, 32'd0);
        chk("R11", "ale", {31'd0, ale}, 32'd0);
        chk("R11", "den", {31'd0, den}, 32'd0);
        chk("R11", "oe", {31'd0, bus_oe}, 32'd0);
        chk("R11", "strobes", {30'd0, rd_n, wr_n}, 32'd3);
        chk("R11", "rd_valid", {31'd0, rd_valid}, 32'd0);
        chk("R11", "req_ready", {31'd0, req_ready}, 32'd1);
        rst = 1'b0;
        step();
        chk("R11", "busy after", {31'd0, busy}, 32'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R1: request offered mid-cycle is ignored
        a = VECS[0];
        offer(a); bus_in = {4'h0, a.busv};
        step(); req_valid = 1'b0;
        step(); step();                       // T2 first clock
        offer(VECS[1]);
        step(); req_valid = 1'b0;
        repeat (6) step();                    // through T4 and into idle
        chk("R1", "mid-cycle offer ignored busy", {31'd0, busy}, 32'd0);
        step();
        chk("R1", "mid-cycle offer ignored ale", {31'd0, ale}, 32'd0);

        // R8: READY outside the sampling clock has no effect
        offer(a);
        step(); req_valid = 1'b0;
        step(); step(); step();
        step(); ready = 1'b1;                 // T3 first clock
        step(); ready = 1'b0;                 // T3 second clock
        step();                               // wait state first clock
        chk("R8", "wait inserted rd_n", {31'd0, rd_n}, 32'd0);
        chk("R8", "wait inserted rd_valid", {31'd0, rd_valid}, 32'd0);
        ready = 1'b1;
        step(); step();                       // T4 first clock
        chk("R8", "data after wait", {31'd0, rd_valid}, 32'd1);
        step(); step();
        chk("R8", "back to idle", {31'd0, busy}, 32'd0);

        // R10: completion of T4 and acceptance coincide
        b = VECS[5];
        offer(a);
        step(); req_valid = 1'b0;
        repeat (6) step();                    // T4 first clock
        offer(b);
        step();                               // T4 second clock
        chk("R10", "req_ready at end", {31'd0, req_ready}, 32'd1);
        step();
        req_valid = 1'b0;
        chk("R10", "ale next clock", {31'd0, ale}, 32'd1);
        chk("R10", "new address", {12'd0, bus_out}, {12'd0, b.addr});
        chk("R10", "new direction", {31'd0, dt_r}, 32'd1);
        for (int k = 0; k < 20 && busy; k++) step();
        chk("R10", "second cycle ends", {31'd0, busy}, 32'd0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule